// File: doc/BRIEF.md
# Hardware Watchpoint Match Unit

This unit watches a processor's instruction-fetch and data-access bus against four programmable debug slots and reports which ones were hit. Each slot has an address register and a 4-bit type/length field in a shared control word. The control word also holds two enable bits per slot: a task-local one and a global one. Every cycle that a bus access is valid, the access is compared with all enabled slots. A slot hits when the access kind suits its type code and the access address falls in the naturally aligned region that the slot's length code selects.

A hit sets a sticky per-slot bit in a status register. It also produces a one-cycle trap pulse in the following cycle, which the core's exception logic consumes. Software sets up and inspects the slots through a simple register write port and a combinational read port. The core pulses a task-switch input when it changes context, and that pulse drops every task-local enable.

Top module: `wpt_match_unit`

## Requirements
- R1: After reset, all four slot addresses, the control word and the status bits read as zero, and the trap output is low.
- R2: The register map is as follows. Select 0..3 are the slot address registers. Select 4 is the control word. Select 5 is the status register, with slot i at bit i. Reads are combinational and unused bits read as zero.
- R3: Slot i is enabled when control bit 2i (local) or bit 2i+1 (global) is set. A slot with both bits clear never hits.
- R4: The type code of slot i is control bits [17+4i:16+4i]. Code 00 matches fetches, 01 matches data writes only, 11 matches data reads and writes, and 10 never matches. The bus kind encoding is 00 fetch, 01 write, 10 read; kind 11 matches nothing.
- R5: The length code of slot i is control bits [19+4i:18+4i]: 00 covers 1 byte, 01 covers 2, 11 covers 4 and 10 covers 8. An access hits when its address and the slot address are equal after both have their low 0, 1, 2 or 3 bits masked off. A fetch-type slot hits only with length code 00.
- R6: A hit on slot i sets status bit i at the next clock edge. The bit stays set until software writes a 1 to it at select 5, and a write of 0 leaves it alone. A hit and a clear in the same cycle leave the bit set.
- R7: A task-switch pulse clears control bits 0, 2, 4 and 6 at the next edge and leaves bits 1, 3, 5 and 7 unchanged. This still holds when a control write happens in the same cycle.
- R8: Control bits 10 to 15 ignore writes and read as zero. Bits 8 and 9 hold whatever was written.
- R9: The trap output is high for exactly the cycle after each cycle in which at least one slot hits a valid access, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select for reads and writes |
| regWdata | input | ADDR_W | Register write data |
| regRdata | output | ADDR_W | Register read data (combinational) |
| taskSwitch | input | 1 | Context-switch pulse; clears local enables |
| busValid | input | 1 | Bus access valid |
| busKind | input | 2 | Access kind: 00 fetch, 01 write, 10 read |
| busAddr | input | ADDR_W | Access byte address |
| trapPulse | output | 1 | Debug trap, one cycle after a hit |

## Verification
The bench builds the unit with its default parameters: a 32-bit address and four slots. With these values the control word is completely populated, so every enable pair, every type/length nibble and the reserved gap between them can be reached. The 32-bit address allows a slot base aligned to 16 bytes, so each of the four lengths can be probed just inside and just past its region edge. Having all four slots also allows global-only, vacant and simultaneous two-slot hits to be tested side by side.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int WPT_IDX_W = 2;
  localparam int WPT_CTRL_W = 32;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_READ  = 2'b10;

  localparam logic [1:0] TYPE_EXEC  = 2'b00;
  localparam logic [1:0] TYPE_WR    = 2'b01;
  localparam logic [1:0] TYPE_RW    = 2'b11;

  // strobes from control decode to datapath
  typedef struct packed {
    logic                 addrWe;
    logic [WPT_IDX_W-1:0] addrIdx;
    logic                 ctrlWe;
    logic                 statClr;
    logic                 taskClr;
  } wptStrobe_t;

  // one bit per slot at position 2*i+off
  function automatic logic [WPT_CTRL_W-1:0] enableMask(input int n, input int off);
    logic [WPT_CTRL_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[2*i+off] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wpt_ctrl.sv
module wpt_ctrl
  import wpt_pkg::*;
(
  input  logic       regWe,
  input  logic [2:0] regSel,
  input  logic       taskSwitch,
  output wptStrobe_t strobe
);
  always_comb begin
    strobe.addrWe  = regWe && (regSel[2] == 1'b0);
    strobe.addrIdx = regSel[WPT_IDX_W-1:0];
    strobe.ctrlWe  = regWe && (regSel == 3'd4);
    strobe.statClr = regWe && (regSel == 3'd5);
    strobe.taskClr = taskSwitch;
  end
endmodule

// File: rtl/wpt_datapath.sv
module wpt_datapath
  import wpt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wptStrobe_t            strobe,
  input  logic [2:0]            regSel,
  input  logic [ADDR_W-1:0]     regWdata,
  output logic [ADDR_W-1:0]     regRdata,
  input  logic                  busValid,
  input  logic [1:0]            busKind,
  input  logic [ADDR_W-1:0]     busAddr,
  output logic                  trapPulse,
  output logic [WPT_CTRL_W-1:0] ctrlWord,
  output logic [NUM_SLOTS-1:0]  statusVec
);
  localparam int NIB_BASE = 16;
  localparam int NIB_W    = 4;
  localparam logic [WPT_CTRL_W-1:0] WRITABLE   = 32'hFFFF_03FF;
  localparam logic [WPT_CTRL_W-1:0] LOCAL_BITS = enableMask(NUM_SLOTS, 0);

  logic [ADDR_W-1:0]     slotAddr [NUM_SLOTS];
  logic [WPT_CTRL_W-1:0] ctrlQ, ctrlNext;
  logic [NUM_SLOTS-1:0]  statusQ, statusNext, hitVec, clrVec;
  logic                  trapQ;

  function automatic logic [ADDR_W-1:0] lenMask(input logic [1:0] code);
    case (code)
      2'b00:   return '0;
      2'b01:   return ADDR_W'(1);
      2'b11:   return ADDR_W'(3);
      default: return ADDR_W'(7);
    endcase
  endfunction

  // per-slot comparators
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic [1:0]        typ, lenC;
    logic              en, kindOk, addrOk;
    logic [ADDR_W-1:0] msk;

    always_comb begin
      en   = |ctrlQ[2*g +: 2];
      typ  = ctrlQ[NIB_BASE + NIB_W*g +: 2];
      lenC = ctrlQ[NIB_BASE + NIB_W*g + 2 +: 2];
      msk  = lenMask(lenC);
      case (typ)
        TYPE_EXEC: kindOk = (busKind == KIND_FETCH) && (lenC == 2'b00);
        TYPE_WR:   kindOk = (busKind == KIND_WRITE);
        TYPE_RW:   kindOk = (busKind == KIND_WRITE) || (busKind == KIND_READ);
        default:   kindOk = 1'b0;
      endcase
      addrOk    = (busAddr & ~msk) == (slotAddr[g] & ~msk);
      hitVec[g] = busValid && en && kindOk && addrOk;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotAddr[g] <= '0;
      else if (strobe.addrWe && (strobe.addrIdx == WPT_IDX_W'(g)))
        slotAddr[g] <= regWdata;
    end
  end

  always_comb begin
    ctrlNext = strobe.ctrlWe ? (regWdata[WPT_CTRL_W-1:0] & WRITABLE) : ctrlQ;
    if (strobe.taskClr) ctrlNext = ctrlNext & ~LOCAL_BITS;
    clrVec     = strobe.statClr ? regWdata[NUM_SLOTS-1:0] : '0;
    statusNext = (statusQ & ~clrVec) | hitVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      statusQ <= '0;
      trapQ   <= 1'b0;
    end else begin
      ctrlQ   <= ctrlNext;
      statusQ <= statusNext;
      trapQ   <= |hitVec;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regSel)
      3'd0, 3'd1, 3'd2, 3'd3:
        if (int'(regSel) < NUM_SLOTS) regRdata = slotAddr[regSel[WPT_IDX_W-1:0]];
      3'd4:    regRdata[WPT_CTRL_W-1:0] = ctrlQ;
      3'd5:    regRdata[NUM_SLOTS-1:0]  = statusQ;
      default: regRdata = '0;
    endcase
  end

  assign trapPulse = trapQ;
  assign ctrlWord  = ctrlQ;
  assign statusVec = statusQ;
endmodule

// File: rtl/wpt_match_unit.sv
module wpt_match_unit
  import wpt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic              taskSwitch,
  input  logic              busValid,
  input  logic [1:0]        busKind,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              trapPulse
);
  wptStrobe_t            strobe;
  logic [WPT_CTRL_W-1:0] ctrlWord;
  logic [NUM_SLOTS-1:0]  statusVec;

  wpt_ctrl ctrl_i (
    .regWe      (regWe),
    .regSel     (regSel),
    .taskSwitch (taskSwitch),
    .strobe     (strobe)
  );

  wpt_datapath #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regSel    (regSel),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .busValid  (busValid),
    .busKind   (busKind),
    .busAddr   (busAddr),
    .trapPulse (trapPulse),
    .ctrlWord  (ctrlWord),
    .statusVec (statusVec)
  );
endmodule

// File: rtl/wpt_match_unit_chk.sv
module wpt_match_unit_chk
  import wpt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWe,
  input logic [2:0]            regSel,
  input logic [ADDR_W-1:0]     regWdata,
  input logic [ADDR_W-1:0]     regRdata,
  input logic                  taskSwitch,
  input logic                  trapPulse,
  input logic [WPT_CTRL_W-1:0] ctrlWord,
  input logic [NUM_SLOTS-1:0]  statusVec
);
  localparam logic [WPT_CTRL_W-1:0] LOC = enableMask(NUM_SLOTS, 0);
  localparam logic [WPT_CTRL_W-1:0] GLB = enableMask(NUM_SLOTS, 1);

  a_r7_local_cleared: assert property (@(posedge clk) disable iff (!rstN)
    taskSwitch |=> ((ctrlWord & LOC) == '0));

  a_r7_global_kept: assert property (@(posedge clk) disable iff (!rstN)
    (taskSwitch && !(regWe && regSel == 3'd4)) |=> ((ctrlWord & GLB) == ($past(ctrlWord) & GLB)));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 3'd4) |-> (regRdata[15:10] == 6'b0));

  a_r9_trap_has_status: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> (statusVec != '0));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSticky
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (statusVec[i] && !(regWe && regSel == 3'd5 && regWdata[i])) |=> statusVec[i]);
  end
endmodule

bind wpt_match_unit wpt_match_unit_chk #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regSel     (regSel),
  .regWdata   (regWdata),
  .regRdata   (regRdata),
  .taskSwitch (taskSwitch),
  .trapPulse  (trapPulse),
  .ctrlWord   (ctrlWord),
  .statusVec  (statusVec)
);

// File: tb/wpt_match_unit_tb_top.sv
`timescale 1ns/1ps
module wpt_match_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regSel = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        taskSwitch = 1'b0;
  logic        busValid = 1'b0;
  logic [1:0]  busKind = 2'b00;
  logic [31:0] busAddr = '0;
  logic        trapPulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wpt_match_unit dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .taskSwitch(taskSwitch), .busValid(busValid),
    .busKind(busKind), .busAddr(busAddr), .trapPulse(trapPulse)
  );

  localparam logic [31:0] SA = 32'h1000_0010;
  localparam logic [31:0] SB = 32'h2000_0040;

  // {type, len, kind, addr, expected hit}
  localparam logic [38:0] VEC [16] = '{
    {2'b01, 2'b00, 2'b01, SA,        1'b1},
    {2'b01, 2'b00, 2'b10, SA,        1'b0},
    {2'b11, 2'b00, 2'b10, SA,        1'b1},
    {2'b11, 2'b00, 2'b01, SA,        1'b1},
    {2'b00, 2'b00, 2'b00, SA,        1'b1},
    {2'b00, 2'b00, 2'b01, SA,        1'b0},
    {2'b10, 2'b00, 2'b01, SA,        1'b0},
    {2'b10, 2'b00, 2'b10, SA,        1'b0},
    {2'b01, 2'b01, 2'b01, SA + 32'd1, 1'b1},
    {2'b01, 2'b01, 2'b01, SA + 32'd2, 1'b0},
    {2'b01, 2'b11, 2'b01, SA + 32'd3, 1'b1},
    {2'b01, 2'b11, 2'b01, SA + 32'd4, 1'b0},
    {2'b01, 2'b10, 2'b01, SA + 32'd7, 1'b1},
    {2'b01, 2'b10, 2'b01, SA + 32'd8, 1'b0},
    {2'b00, 2'b11, 2'b00, SA,        1'b0},
    {2'b01, 2'b00, 2'b01, SA + 32'd1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] sel, input logic [31:0] exp, input string req);
    regSel = sel;
    #1;
    check(regRdata == exp, req, regRdata, exp);
  endtask

  // drive one access; returns just after the capturing edge
  task automatic access(input logic [1:0] k, input logic [31:0] a);
    @(negedge clk);
    busValid = 1'b1; busKind = k; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 6; s++) rdChk(3'(s), 32'h0, "R1 reset read");
    check(trapPulse == 1'b0, "R1 trap reset", {31'b0, trapPulse}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table-driven matching: R4 type codes, R5 lengths, R9 trap, R6 set
    for (int k = 0; k < 16; k++) begin
      logic [1:0] typ, len, kind;
      logic [31:0] a;
      logic e;
      {typ, len, kind, a, e} = VEC[k];
      wrReg(3'd0, SA);
      wrReg(3'd4, 32'h1 | ({28'b0, len, typ} << 16));
      wrReg(3'd5, 32'hF);
      access(kind, a);
      check(trapPulse == e, $sformatf("R4/R5/R9 vec %0d trap", k), {31'b0, trapPulse}, {31'b0, e});
      rdChk(3'd5, {31'b0, e}, $sformatf("R6 vec %0d status", k));
      @(negedge clk);
      check(trapPulse == 1'b0, "R9 trap one cycle", {31'b0, trapPulse}, 32'h0);
    end

    // R2 address readback
    wrReg(3'd1, 32'hDEAD_BEE0);
    wrReg(3'd2, SB);
    wrReg(3'd3, SB);
    rdChk(3'd1, 32'hDEAD_BEE0, "R2 slot1 readback");
    rdChk(3'd2, SB, "R2 slot2 readback");
    rdChk(3'd6, 32'h0, "R2 unused select");

    // R8 reserved bits
    wrReg(3'd4, 32'hFFFF_FFFF);
    rdChk(3'd4, 32'hFFFF_03FF, "R8 reserved bits");
    // R7 task switch clears local only
    wrReg(3'd4, 32'h0000_00FF);
    @(negedge clk); taskSwitch = 1'b1;
    @(negedge clk); taskSwitch = 1'b0;
    rdChk(3'd4, 32'h0000_00AA, "R7 task switch");

    // R3/R7: slot2 global only, slot3 vacant; both write-type 1-byte
    wrReg(3'd4, 32'h1100_0020);
    wrReg(3'd5, 32'hF);
    @(negedge clk); taskSwitch = 1'b1;
    @(negedge clk); taskSwitch = 1'b0;
    access(2'b01, SB);
    check(trapPulse == 1'b1, "R3 global slot trap", {31'b0, trapPulse}, 32'h1);
    rdChk(3'd5, 32'h4, "R3 vacant slot3 no hit");

    // two slots at once
    wrReg(3'd4, 32'h1100_0060);
    access(2'b01, SB);
    rdChk(3'd5, 32'hC, "R3 two slots hit");

    // R6 sticky and write-one-to-clear
    repeat (4) @(negedge clk);
    rdChk(3'd5, 32'hC, "R6 sticky");
    wrReg(3'd5, 32'h4);
    rdChk(3'd5, 32'h8, "R6 clear one bit");
    wrReg(3'd5, 32'h0);
    rdChk(3'd5, 32'h8, "R6 write zero no effect");

    // R6 set wins over simultaneous clear
    @(negedge clk);
    busValid = 1'b1; busKind = 2'b01; busAddr = SB;
    regWe = 1'b1; regSel = 3'd5; regWdata = 32'hC;
    @(negedge clk);
    busValid = 1'b0; regWe = 1'b0;
    check(trapPulse == 1'b1, "R9 trap with clear", {31'b0, trapPulse}, 32'h1);
    rdChk(3'd5, 32'hC, "R6 set beats clear");

    // R4 kind 11 never matches a read/write slot
    wrReg(3'd5, 32'hF);
    access(2'b11, SB);
    check(trapPulse == 1'b0, "R4 kind 11 no match", {31'b0, trapPulse}, 32'h0);
    rdChk(3'd5, 32'h0, "R4 kind 11 status");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule